// File: doc/BRIEF.md
# Effective Address Generator

This block turns a decoded memory-operand description into the address the bus cycle will use. Each request carries a 3-bit addressing-mode code, two register selects, a displacement-enable flag, a 16-bit displacement, a snapshot of the four pointer registers (two bases, two indexes) and the four segment registers. It also carries an optional segment override. One clock after a request is accepted, the block presents three results together with a valid strobe:

- a 16-bit offset;
- a 20-bit physical address;
- a no-memory flag.

The offset is the wrapped sum of the selected base register, the selected index register and the displacement, taking only the terms the mode calls for. The physical address is the chosen segment register shifted left by four bits, plus the offset, truncated to 20 bits. This covers a 1 MB space in windows of up to 64 KB.

Register and immediate operands need no memory access. The block flags these requests and returns zero for both address results. The segment defaults to stack when the second base register (BP) is the base, and to data otherwise. A valid override replaces that default.

Top module: `eff_addr_unit`

## Requirements
- R1: While `rst_n` is low and on the first clock after its release, `out_valid`, `out_nomem`, `out_offset` and `out_phys` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. All result outputs change in that same cycle.
- R3: Mode codes 0 (register), 1 (immediate), 6 and 7 (reserved) set `out_nomem` to 1 and return `out_offset` = 0 and `out_phys` = 0. Codes 2 to 5 set `out_nomem` to 0.
- R4: Mode code 2 (direct) gives `out_offset` = `disp`, whatever the value of `disp_en`.
- R5: Mode code 3 (base only) gives `out_offset` = base + (`disp_en` ? `disp` : 0). The base is `reg_bx` when `base_sel`=0 and `reg_bp` when `base_sel`=1.
- R6: Mode code 4 (index only) gives `out_offset` = index + (`disp_en` ? `disp` : 0). The index is `reg_si` when `index_sel`=0 and `reg_di` when `index_sel`=1.
- R7: Mode code 5 (base plus index) gives `out_offset` = base + index + (`disp_en` ? `disp` : 0), for all four pairings of `base_sel` and `index_sel`.
- R8: The offset sum wraps modulo 2^16.
- R9: With `ovr_valid`=0, the segment is `seg_stack` when the mode is 3 or 5 and `base_sel`=1, and `seg_data` in every other memory mode.
- R10: With `ovr_valid`=1, the segment is chosen by `ovr_seg`: 0 = data, 1 = code, 2 = stack, 3 = extra.
- R11: For memory modes, `out_phys` = (segment × 16 + `out_offset`) mod 2^20.
- R12: In a cycle after one in which `req_valid` was low, `out_nomem`, `out_offset` and `out_phys` keep their previous values, whatever the other inputs did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing-mode code |
| base_sel | input | 1 | 0 = BX base, 1 = BP base |
| index_sel | input | 1 | 0 = SI index, 1 = DI index |
| disp_en | input | 1 | Add displacement in base/index modes |
| disp | input | 16 | Displacement or direct address |
| reg_bx | input | 16 | First base register |
| reg_bp | input | 16 | Second base register |
| reg_si | input | 16 | First index register |
| reg_di | input | 16 | Second index register |
| seg_code | input | 16 | Code segment |
| seg_data | input | 16 | Data segment |
| seg_stack | input | 16 | Stack segment |
| seg_extra | input | 16 | Extra segment |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| out_valid | output | 1 | Results valid |
| out_nomem | output | 1 | Operand needs no memory access |
| out_offset | output | 16 | Effective offset |
| out_phys | output | 20 | Physical address |

## Verification
The bench forces three-term sums past 0xFFFF. A design that carried into a 17th offset bit would then add 0x10000 to the physical address instead of wrapping the offset first. It also places a segment near the top of the space so the physical sum passes 2^20, which exposes a design that saturated or kept a 21st bit. It covers all four base/index pairings, the BP-based defaults with and without an index, and every override code, so a swapped select or a stack default applied to the wrong mode shows up as a wrong segment in `out_phys`. Idle cycles with changing inputs catch a design that let its result registers follow the inputs without a request.

// File: rtl/eff_addr_pkg.sv
package eff_addr_pkg;

  localparam logic [2:0] AM_REG      = 3'd0;
  localparam logic [2:0] AM_IMM      = 3'd1;
  localparam logic [2:0] AM_DIRECT   = 3'd2;
  localparam logic [2:0] AM_BASE     = 3'd3;
  localparam logic [2:0] AM_INDEX    = 3'd4;
  localparam logic [2:0] AM_BASE_IDX = 3'd5;

  localparam logic [1:0] SG_DATA  = 2'd0;
  localparam logic [1:0] SG_CODE  = 2'd1;
  localparam logic [1:0] SG_STACK = 2'd2;
  localparam logic [1:0] SG_EXTRA = 2'd3;

  localparam int unsigned NUM_SEGS = 4;

  function automatic logic mode_is_mem(input logic [2:0] m);
    return (m == AM_DIRECT) || (m == AM_BASE) || (m == AM_INDEX) || (m == AM_BASE_IDX);
  endfunction

  function automatic logic mode_has_base(input logic [2:0] m);
    return (m == AM_BASE) || (m == AM_BASE_IDX);
  endfunction

  function automatic logic mode_has_index(input logic [2:0] m);
    return (m == AM_INDEX) || (m == AM_BASE_IDX);
  endfunction

endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
  import eff_addr_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic [2:0]       mode,
  input  logic             base_sel,
  input  logic             index_sel,
  input  logic             disp_en,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  output logic [OFS_W-1:0] offset,
  output logic             nomem,
  output logic             bp_based
);

  localparam int ACC_W = OFS_W + 2;

  function automatic logic [OFS_W-1:0] wrap_add3(
    input logic [OFS_W-1:0] a,
    input logic [OFS_W-1:0] b,
    input logic [OFS_W-1:0] c
  );
    logic [ACC_W-1:0] acc;
    acc = {2'b00, a} + {2'b00, b} + {2'b00, c};
    return acc[OFS_W-1:0];
  endfunction

  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] index_term;
  logic [OFS_W-1:0] disp_term;

  always_comb begin
    nomem      = !mode_is_mem(mode);
    bp_based   = mode_has_base(mode) && base_sel;
    base_term  = mode_has_base(mode)  ? (base_sel  ? reg_bp : reg_bx) : '0;
    index_term = mode_has_index(mode) ? (index_sel ? reg_di : reg_si) : '0;
    if (mode == AM_DIRECT)
      disp_term = disp;
    else
      disp_term = disp_en ? disp : '0;
    offset = nomem ? '0 : wrap_add3(base_term, index_term, disp_term);
  end

endmodule

// File: rtl/ea_seg_select.sv
module ea_seg_select
  import eff_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [SEG_W-1:0] seg_code,
  input  logic [SEG_W-1:0] seg_data,
  input  logic [SEG_W-1:0] seg_stack,
  input  logic [SEG_W-1:0] seg_extra,
  input  logic             bp_based,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_seg,
  output logic [SEG_W-1:0] seg_value
);

  logic [1:0]          pick;
  logic [SEG_W-1:0]    seg_tab [NUM_SEGS];
  logic [NUM_SEGS-1:0] pick_hit;

  always_comb begin
    seg_tab[SG_DATA]  = seg_data;
    seg_tab[SG_CODE]  = seg_code;
    seg_tab[SG_STACK] = seg_stack;
    seg_tab[SG_EXTRA] = seg_extra;
    if (ovr_valid)
      pick = ovr_seg;
    else
      pick = bp_based ? SG_STACK : SG_DATA;
  end

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_hit
    assign pick_hit[g] = (pick == 2'(g));
  end

  always_comb begin
    seg_value = '0;
    for (int k = 0; k < NUM_SEGS; k++) begin
      if (pick_hit[k]) seg_value = seg_tab[k];
    end
  end

endmodule

// File: rtl/ea_phys_combine.sv
module ea_phys_combine #(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input  logic [SEG_W-1:0] seg_value,
  input  logic [OFS_W-1:0] offset,
  input  logic             nomem,
  output logic [PA_W-1:0]  phys
);

  localparam int SHIFTED_W = SEG_W + SEG_SHIFT;
  localparam int SUM_W     = ((SHIFTED_W > OFS_W) ? SHIFTED_W : OFS_W) + 1;

  function automatic logic [PA_W-1:0] fold(
    input logic [SEG_W-1:0] s,
    input logic [OFS_W-1:0] o
  );
    logic [SUM_W-1:0] acc;
    acc = SUM_W'({s, {SEG_SHIFT{1'b0}}}) + SUM_W'(o);
    return acc[PA_W-1:0];
  endfunction

  assign phys = nomem ? '0 : fold(seg_value, offset);

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eff_addr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       mode,
  input  logic             base_sel,
  input  logic             index_sel,
  input  logic             disp_en,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic [SEG_W-1:0] seg_code,
  input  logic [SEG_W-1:0] seg_data,
  input  logic [SEG_W-1:0] seg_stack,
  input  logic [SEG_W-1:0] seg_extra,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_seg,
  output logic             out_valid,
  output logic             out_nomem,
  output logic [OFS_W-1:0] out_offset,
  output logic [PA_W-1:0]  out_phys
);

  logic [OFS_W-1:0] off_c;
  logic             nomem_c;
  logic             bp_based_c;
  logic [SEG_W-1:0] seg_c;
  logic [PA_W-1:0]  phys_c;

  // Named events brought out for the checker
  logic             ev_accept;
  logic             ev_mem_ref;
  logic [SEG_W-1:0] seg_q;

  assign ev_accept  = req_valid;
  assign ev_mem_ref = req_valid && !nomem_c;

  ea_offset_calc #(.OFS_W(OFS_W)) u_ofs (
    .mode      (mode),
    .base_sel  (base_sel),
    .index_sel (index_sel),
    .disp_en   (disp_en),
    .disp      (disp),
    .reg_bx    (reg_bx),
    .reg_bp    (reg_bp),
    .reg_si    (reg_si),
    .reg_di    (reg_di),
    .offset    (off_c),
    .nomem     (nomem_c),
    .bp_based  (bp_based_c)
  );

  ea_seg_select #(.SEG_W(SEG_W)) u_seg (
    .seg_code  (seg_code),
    .seg_data  (seg_data),
    .seg_stack (seg_stack),
    .seg_extra (seg_extra),
    .bp_based  (bp_based_c),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .seg_value (seg_c)
  );

  ea_phys_combine #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)
  ) u_phys (
    .seg_value (seg_c),
    .offset    (off_c),
    .nomem     (nomem_c),
    .phys      (phys_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_nomem  <= 1'b0;
      out_offset <= '0;
      out_phys   <= '0;
      seg_q      <= '0;
    end else begin
      out_valid <= ev_accept;
      if (ev_accept) begin
        out_nomem  <= nomem_c;
        out_offset <= off_c;
        out_phys   <= phys_c;
        seg_q      <= seg_c;
      end
    end
  end

endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk
  import eff_addr_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_accept,
  input logic             ev_mem_ref,
  input logic [2:0]       mode,
  input logic [OFS_W-1:0] disp,
  input logic             out_valid,
  input logic             out_nomem,
  input logic [OFS_W-1:0] out_offset,
  input logic [PA_W-1:0]  out_phys,
  input logic [SEG_W-1:0] seg_q
);

  localparam int WIDE_W = SEG_W + SEG_SHIFT + OFS_W + 1;

  function automatic logic [PA_W-1:0] expect_phys(
    input logic [SEG_W-1:0] s,
    input logic [OFS_W-1:0] o
  );
    logic [WIDE_W-1:0] w;
    w = (WIDE_W'(s) << SEG_SHIFT) + WIDE_W'(o);
    return w[PA_W-1:0];
  endfunction

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> out_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> !out_valid);

  a_r3_nomem_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nomem) |-> (out_offset == '0 && out_phys == '0));

  a_r3_nomem_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && (mode == AM_REG || mode == AM_IMM)) |=> out_nomem);

  a_r3_memref_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_ref |=> !out_nomem);

  a_r4_direct_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && mode == AM_DIRECT) |=> (out_offset == $past(disp)));

  a_r11_phys_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nomem) |-> (out_phys == expect_phys(seg_q, out_offset)));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> ($stable(out_offset) && $stable(out_phys) && $stable(out_nomem)));

endmodule

bind eff_addr_unit eff_addr_unit_chk #(
  .OFS_W(OFS_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_accept  (ev_accept),
  .ev_mem_ref (ev_mem_ref),
  .mode       (mode),
  .disp       (disp),
  .out_valid  (out_valid),
  .out_nomem  (out_nomem),
  .out_offset (out_offset),
  .out_phys   (out_phys),
  .seg_q      (seg_q)
);

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic        base_sel = 1'b0;
  logic        index_sel = 1'b0;
  logic        disp_en = 1'b0;
  logic [15:0] disp = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_code = '0, seg_data = '0, seg_stack = '0, seg_extra = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic        out_valid;
  logic        out_nomem;
  logic [15:0] out_offset;
  logic [19:0] out_phys;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eff_addr_unit u_eff_addr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .base_sel(base_sel), .index_sel(index_sel), .disp_en(disp_en), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_code(seg_code), .seg_data(seg_data), .seg_stack(seg_stack),
    .seg_extra(seg_extra), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .out_valid(out_valid), .out_nomem(out_nomem), .out_offset(out_offset),
    .out_phys(out_phys)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bench model, written from the requirements
  function automatic bit b_is_mem(input logic [2:0] m);
    return m >= 3'd2 && m <= 3'd5;
  endfunction

  function automatic int unsigned b_offset();
    int unsigned s = 0;
    case (mode)
      3'd2: s = disp;
      3'd3: s = (base_sel ? reg_bp : reg_bx) + (disp_en ? disp : 0);
      3'd4: s = (index_sel ? reg_di : reg_si) + (disp_en ? disp : 0);
      3'd5: s = (base_sel ? reg_bp : reg_bx) + (index_sel ? reg_di : reg_si)
                + (disp_en ? disp : 0);
      default: s = 0;
    endcase
    return s % 65536;
  endfunction

  function automatic int unsigned b_segment();
    if (ovr_valid) begin
      case (ovr_seg)
        2'd0: return seg_data;
        2'd1: return seg_code;
        2'd2: return seg_stack;
        default: return seg_extra;
      endcase
    end
    if ((mode == 3'd3 || mode == 3'd5) && base_sel) return seg_stack;
    return seg_data;
  endfunction

  function automatic int unsigned b_phys();
    if (!b_is_mem(mode)) return 0;
    return (b_segment() * 16 + b_offset()) % (1 << 20);
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R3";
    endcase
  endfunction

  // Called at a negedge with inputs set; checks one cycle later at the next negedge
  task automatic issue(input string otag, input string ptag);
    logic        e_nomem;
    logic [15:0] e_off;
    logic [19:0] e_phys;
    req_valid = 1'b1;
    e_nomem = !b_is_mem(mode);
    e_off   = 16'(b_offset());
    e_phys  = 20'(b_phys());
    @(posedge clk);
    @(negedge clk);
    check("R2", "out_valid", {31'b0, out_valid}, 32'd1);
    check("R3", "out_nomem", {31'b0, out_nomem}, {31'b0, e_nomem});
    check(otag, "out_offset", {16'b0, out_offset}, {16'b0, e_off});
    check(ptag, "out_phys", {12'b0, out_phys}, {12'b0, e_phys});
    req_valid = 1'b0;
  endtask

  task automatic scramble();
    mode = 3'($urandom_range(0, 7));
    base_sel = 1'($urandom); index_sel = 1'($urandom); disp_en = 1'($urandom);
    disp = 16'($urandom);
    reg_bx = 16'($urandom); reg_bp = 16'($urandom);
    reg_si = 16'($urandom); reg_di = 16'($urandom);
    seg_code = 16'($urandom); seg_data = 16'($urandom);
    seg_stack = 16'($urandom); seg_extra = 16'($urandom);
    ovr_valid = ($urandom_range(0, 3) == 0); ovr_seg = 2'($urandom);
  endtask

  // Idle cycle with changing inputs: results must hold, valid must drop
  task automatic idle_check();
    logic        h_nomem = out_nomem;
    logic [15:0] h_off   = out_offset;
    logic [19:0] h_phys  = out_phys;
    req_valid = 1'b0;
    scramble();
    @(posedge clk);
    @(negedge clk);
    check("R2", "out_valid idle", {31'b0, out_valid}, 32'd0);
    check("R12", "hold nomem", {31'b0, out_nomem}, {31'b0, h_nomem});
    check("R12", "hold offset", {16'b0, out_offset}, {16'b0, h_off});
    check("R12", "hold phys", {12'b0, out_phys}, {12'b0, h_phys});
  endtask

  task automatic set_regs(input logic [15:0] bx, bp, si, di);
    reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di;
  endtask

  task automatic set_segs(input logic [15:0] cs, ds, ss, es);
    seg_code = cs; seg_data = ds; seg_stack = ss; seg_extra = es;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd31337));
    // R1: reset state, during reset and right after release
    @(negedge clk);
    @(negedge clk);
    check("R1", "valid in reset", {31'b0, out_valid}, 32'd0);
    check("R1", "offset in reset", {16'b0, out_offset}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "valid after release", {31'b0, out_valid}, 32'd0);
    check("R1", "nomem after release", {31'b0, out_nomem}, 32'd0);
    check("R1", "phys after release", {12'b0, out_phys}, 32'd0);

    set_segs(16'h2000, 16'h1000, 16'h3000, 16'h4000);
    set_regs(16'h0100, 16'h0200, 16'h0030, 16'h0040);
    disp = 16'h1234;

    // R3: register, immediate and reserved codes
    mode = 3'd0; issue("R3", "R3");
    mode = 3'd1; issue("R3", "R3");
    mode = 3'd6; issue("R3", "R3");
    mode = 3'd7; issue("R3", "R3");

    // R4: direct, displacement enable ignored; DS=1000 -> phys 0x19000
    mode = 3'd2; disp = 16'h9000; disp_en = 1'b0; issue("R4", "R11");
    check("R11", "direct phys", {12'b0, out_phys}, 32'h19000);

    // R5: base only, disp_en=0 drops the displacement
    mode = 3'd3; base_sel = 1'b0; disp_en = 1'b0; issue("R5", "R9");
    check("R5", "bx only", {16'b0, out_offset}, 32'h0100);
    base_sel = 1'b1; disp_en = 1'b1; disp = 16'h0010; issue("R5", "R9");
    check("R9", "bp base uses stack", {12'b0, out_phys}, 32'h30210);

    // R6: index only
    mode = 3'd4; index_sel = 1'b1; disp_en = 1'b1; disp = 16'h0005; issue("R6", "R9");
    check("R6", "di plus disp", {16'b0, out_offset}, 32'h0045);

    // R7: all four base/index pairings, R9 stack default for BP
    mode = 3'd5; disp_en = 1'b1; disp = 16'h1000;
    for (int p = 0; p < 4; p++) begin
      base_sel = p[1]; index_sel = p[0];
      issue("R7", "R9");
    end

    // R8: offset wrap before the segment is added
    set_regs(16'hFFFF, 16'h0000, 16'h0002, 16'h0000);
    mode = 3'd5; base_sel = 1'b0; index_sel = 1'b0; disp = 16'h0001; disp_en = 1'b1;
    issue("R8", "R11");
    check("R8", "wrapped offset", {16'b0, out_offset}, 32'h0002);
    check("R8", "no carry into phys", {12'b0, out_phys}, 32'h10002);

    // R10: every override code
    mode = 3'd3; base_sel = 1'b1; disp_en = 1'b0; ovr_valid = 1'b1;
    for (int c = 0; c < 4; c++) begin
      ovr_seg = 2'(c);
      issue("R5", "R10");
    end
    ovr_valid = 1'b0;

    // R11: physical wrap past 1 MB
    set_segs(16'h0000, 16'hFFFF, 16'h0000, 16'h0000);
    mode = 3'd2; disp = 16'h0020; issue("R4", "R11");
    check("R11", "phys wraps 20 bits", {12'b0, out_phys}, 32'h00010);

    // R12: idle cycles hold
    idle_check();
    idle_check();

    // Constrained random mix with idle gaps
    for (int i = 0; i < 400; i++) begin
      scramble();
      issue(mode_tag(mode), ovr_valid ? "R10" : (b_is_mem(mode) ? "R11" : "R3"));
      if ($urandom_range(0, 4) == 0) idle_check();
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule